// File: doc/BRIEF.md
# Programmable AND-Term with Delay Filter

This block is one programmable logic term of a supply supervisor or power sequencer. It watches 21 status signals: eight outputs of neighbouring logic terms, seven supply-fault flags, four general-purpose inputs and two watchdog signals. Each signal first passes through its own polarity inverter and its own mask. A masked signal contributes a constant 1. The 21 conditioned legs meet in one wide AND gate, and a master enable gates the result. The gated result, called the term value, drives the output through a filter. The filter makes the output rise only after the term value has held 1 for a programmed time, and fall only after it has held 0 for a separately programmed time.

The filter is a four-state machine. In OUT_LOW the output is 0 and the machine waits for the term value to go to 1. If the rise delay is zero it moves straight to OUT_HIGH; otherwise it moves to RISE_WAIT. In RISE_WAIT the output is 0 and the machine counts timebase ticks. It returns to OUT_LOW if the term value drops, and moves to OUT_HIGH when the count reaches the rise delay. OUT_HIGH and FALL_WAIT mirror these two states using the fall delay. A write to the delay register clears a count that is in progress.

Configuration sits in a small register file written through a one-cycle address/data strobe. A typical setup ignores every non-supply input, inverts every supply flag and sets a rise delay. The output then enables a regulator a fixed time after all supplies come into tolerance.

Top module: `pterm_delay`

## Requirements
- R1: After reset every configuration register is 0 and `term_out` is 0. `term_out` stays 0 even when all 21 inputs are 1, because the enable bit is clear.
- R2: A set ignore bit forces its leg to 1, so toggling an ignored input never changes `term_out`. The ignore registers are: address 1 bits 7:0 for block inputs 7:0, address 3 bits 6:0 for supply flags 6:0, and address 5 bits 7:4 for general inputs 3:0.
- R3: A leg that is not ignored equals its input XOR its invert bit. The invert registers are: address 0 bits 7:0 for block inputs, address 2 bits 6:0 for supply flags, and address 4 bits 7:4 for general inputs 3:0.
- R4: All bit positions are decoded as listed in R2, R3 and here. Address 6 holds the watchdog controls: bit 7 inverts `wdog_in[0]`, bit 6 ignores it, bit 5 inverts `wdog_in[1]`, and bit 4 ignores it.
- R5: The term value is 0 whenever bit 1 of address 7 is clear; the other bits of address 7 have no effect. Clearing the bit with zero fall delay drops `term_out` one clock after the write.
- R6: Address 12 bits 7:4 hold the rise code. Code 0 means no delay. A code c from 1 to 15 means m·10^d ticks, where d = (c−1)/3 and m is 1, 2 or 5 for (c−1) mod 3 = 0, 1 or 2. `term_out` rises only after the term value has held 1 for that many ticks.
- R7: Address 12 bits 3:0 hold the fall code, using the same table. `term_out` falls only after the term value has held 0 for that many ticks.
- R8: If the term value changes back before a rise or fall delay completes, `term_out` keeps its level and the delay count starts again from zero.
- R9: With a code of 0, `term_out` follows the term value one clock later.
- R10: A write to address 12 during a delay restarts the count under the new code.
- R11: The delay count advances only in cycles where `tick_ms` is 1.
- R12: With non-supply inputs ignored, supply flags inverted (a flag is 1 for a fault) and rise code 8 (200 ticks), `term_out` rises 200 ticks after the last supply comes into tolerance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | Timebase strobe; one delay unit per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| blk_in | input | 8 | Outputs of neighbouring logic terms |
| sfault_in | input | 7 | Supply-fault flags, 1 = faulted |
| gp_in | input | 4 | General-purpose inputs |
| wdog_in | input | 2 | Watchdog-related inputs |
| term_out | output | 1 | Filtered term output |

## Verification
The term value is combinational from the inputs and the registers. A change on an input therefore reaches `term_out` at the first clock after it when the delay code is 0. A register write reaches it at the first clock after the write edge. With a nonzero code and `tick_ms` held high, `term_out` changes at the clock that is L+1 edges after the input change, where L is the delay from the table. The bench counts clock edges and queues each expected value against the exact edge number at which it is due. It checks both the last cycle before the change and the cycle of the change, sampling on the falling edge. For the cases where the bench holds `tick_ms` low, the due edge is pushed out by the number of edges without a tick.

// File: rtl/pterm_pkg.sv
package pterm_pkg;

    parameter int N_BLK  = 8;
    parameter int N_SF   = 7;
    parameter int N_GP   = 4;
    parameter int N_WD   = 2;
    parameter int N_LEG  = N_BLK + N_SF + N_GP + N_WD;
    parameter int ADDR_W = 4;
    parameter int DATA_W = 8;
    parameter int CODE_W = 4;
    parameter int CNT_W  = 16;

    localparam int GP_LSB = DATA_W - N_GP;
    localparam int WD_LSB = DATA_W - 2 * N_WD;

    localparam logic [ADDR_W-1:0] A_BLK_INV = 4'h0;
    localparam logic [ADDR_W-1:0] A_BLK_IGN = 4'h1;
    localparam logic [ADDR_W-1:0] A_SF_INV  = 4'h2;
    localparam logic [ADDR_W-1:0] A_SF_IGN  = 4'h3;
    localparam logic [ADDR_W-1:0] A_GP_INV  = 4'h4;
    localparam logic [ADDR_W-1:0] A_GP_IGN  = 4'h5;
    localparam logic [ADDR_W-1:0] A_WD_CTL  = 4'h6;
    localparam logic [ADDR_W-1:0] A_ENABLE  = 4'h7;
    localparam logic [ADDR_W-1:0] A_DELAY   = 4'hC;
    localparam int EN_BIT = 1;

    typedef enum logic [1:0] {
        OUT_LOW   = 2'd0,
        RISE_WAIT = 2'd1,
        OUT_HIGH  = 2'd2,
        FALL_WAIT = 2'd3
    } filt_state_t;

    // 1-2-5 series: code c>0 gives m * 10^((c-1)/3) ticks
    function automatic logic [CNT_W-1:0] code_to_ticks(input logic [CODE_W-1:0] c);
        int idx;
        int v;
        if (c == '0) return '0;
        idx = int'(c) - 1;
        case (idx % 3)
            0:       v = 1;
            1:       v = 2;
            default: v = 5;
        endcase
        for (int k = 0; k < 8; k++) begin
            if (k < idx / 3) v = v * 10;
        end
        return CNT_W'(v);
    endfunction

endpackage

// File: rtl/pterm_cfg.sv
module pterm_cfg
    import pterm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [N_LEG-1:0]     inv_bits,
    output logic [N_LEG-1:0]     ign_bits,
    output logic                 func_en,
    output logic [CODE_W-1:0]    rise_code,
    output logic [CODE_W-1:0]    fall_code,
    output logic                 code_upd
);

    logic [N_BLK-1:0]   blk_inv, blk_ign;
    logic [N_SF-1:0]    sf_inv, sf_ign;
    logic [N_GP-1:0]    gp_inv, gp_ign;
    logic [2*N_WD-1:0]  wd_ctl;
    logic               en_q;
    logic [2*CODE_W-1:0] dly_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_inv <= '0;
            blk_ign <= '0;
            sf_inv  <= '0;
            sf_ign  <= '0;
            gp_inv  <= '0;
            gp_ign  <= '0;
            wd_ctl  <= '0;
            en_q    <= 1'b0;
            dly_q   <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                A_BLK_INV: blk_inv <= wr_data[N_BLK-1:0];
                A_BLK_IGN: blk_ign <= wr_data[N_BLK-1:0];
                A_SF_INV:  sf_inv  <= wr_data[N_SF-1:0];
                A_SF_IGN:  sf_ign  <= wr_data[N_SF-1:0];
                A_GP_INV:  gp_inv  <= wr_data[GP_LSB +: N_GP];
                A_GP_IGN:  gp_ign  <= wr_data[GP_LSB +: N_GP];
                A_WD_CTL:  wd_ctl  <= wr_data[WD_LSB +: 2*N_WD];
                A_ENABLE:  en_q    <= wr_data[EN_BIT];
                A_DELAY:   dly_q   <= wr_data[2*CODE_W-1:0];
                default: ;
            endcase
        end
    end

    // Watchdog control nibble, high to low: inv0, ign0, inv1, ign1
    logic [N_WD-1:0] wd_inv, wd_ign;
    generate
        for (genvar w = 0; w < N_WD; w++) begin : g_wd
            assign wd_inv[w] = wd_ctl[2*N_WD-1-2*w];
            assign wd_ign[w] = wd_ctl[2*N_WD-2-2*w];
        end
    endgenerate

    assign inv_bits  = {wd_inv, gp_inv, sf_inv, blk_inv};
    assign ign_bits  = {wd_ign, gp_ign, sf_ign, blk_ign};
    assign func_en   = en_q;
    assign rise_code = dly_q[2*CODE_W-1:CODE_W];
    assign fall_code = dly_q[CODE_W-1:0];
    assign code_upd  = wr_en && (wr_addr == A_DELAY);

endmodule

// File: rtl/pterm_and.sv
module pterm_and
    import pterm_pkg::*;
(
    input  logic [N_LEG-1:0] legs_in,
    input  logic [N_LEG-1:0] inv_bits,
    input  logic [N_LEG-1:0] ign_bits,
    input  logic             func_en,
    output logic             and_res
);

    logic [N_LEG-1:0] leg_ok;

    generate
        for (genvar i = 0; i < N_LEG; i++) begin : g_leg
            assign leg_ok[i] = ign_bits[i] | (legs_in[i] ^ inv_bits[i]);
        end
    endgenerate

    assign and_res = func_en & (&leg_ok);

endmodule

// File: rtl/pterm_filter.sv
module pterm_filter
    import pterm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic              func_in,
    input  logic [CODE_W-1:0] rise_code,
    input  logic [CODE_W-1:0] fall_code,
    input  logic              restart,
    output logic              filt_out,
    output filt_state_t       state_q
);

    filt_state_t      state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] rise_len, fall_len;
    logic [CNT_W:0]   cnt_inc;

    assign rise_len = code_to_ticks(rise_code);
    assign fall_len = code_to_ticks(fall_code);
    assign cnt_inc  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            OUT_LOW: begin
                if (func_in) begin
                    cnt_d   = '0;
                    state_d = (rise_len == '0) ? OUT_HIGH : RISE_WAIT;
                end
            end
            RISE_WAIT: begin
                if (!func_in) begin
                    state_d = OUT_LOW;
                    cnt_d   = '0;
                end else if (rise_len == '0) begin
                    state_d = OUT_HIGH;
                    cnt_d   = '0;
                end else if (restart) begin
                    cnt_d = '0;
                end else if (tick_ms) begin
                    if (cnt_inc >= {1'b0, rise_len}) begin
                        state_d = OUT_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            OUT_HIGH: begin
                if (!func_in) begin
                    cnt_d   = '0;
                    state_d = (fall_len == '0) ? OUT_LOW : FALL_WAIT;
                end
            end
            FALL_WAIT: begin
                if (func_in) begin
                    state_d = OUT_HIGH;
                    cnt_d   = '0;
                end else if (fall_len == '0) begin
                    state_d = OUT_LOW;
                    cnt_d   = '0;
                end else if (restart) begin
                    cnt_d = '0;
                end else if (tick_ms) begin
                    if (cnt_inc >= {1'b0, fall_len}) begin
                        state_d = OUT_LOW;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc[CNT_W-1:0];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        unique case (state_q)
            OUT_LOW, RISE_WAIT:  filt_out = 1'b0;
            OUT_HIGH, FALL_WAIT: filt_out = 1'b1;
        endcase
    end

endmodule

// File: rtl/pterm_delay.sv
module pterm_delay
    import pterm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_ms,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [N_BLK-1:0]    blk_in,
    input  logic [N_SF-1:0]     sfault_in,
    input  logic [N_GP-1:0]     gp_in,
    input  logic [N_WD-1:0]     wdog_in,
    output logic                term_out
);

    logic [N_LEG-1:0]  inv_bits, ign_bits;
    logic              func_en;
    logic [CODE_W-1:0] rise_code, fall_code;
    logic              code_upd;
    logic              and_res;
    filt_state_t       dly_state;

    pterm_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .inv_bits  (inv_bits),
        .ign_bits  (ign_bits),
        .func_en   (func_en),
        .rise_code (rise_code),
        .fall_code (fall_code),
        .code_upd  (code_upd)
    );

    pterm_and u_and (
        .legs_in  ({wdog_in, gp_in, sfault_in, blk_in}),
        .inv_bits (inv_bits),
        .ign_bits (ign_bits),
        .func_en  (func_en),
        .and_res  (and_res)
    );

    pterm_filter u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_ms   (tick_ms),
        .func_in   (and_res),
        .rise_code (rise_code),
        .fall_code (fall_code),
        .restart   (code_upd),
        .filt_out  (term_out),
        .state_q   (dly_state)
    );

endmodule

// File: rtl/pterm_delay_chk.sv
module pterm_delay_chk
    import pterm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              term_out,
    input logic              and_res,
    input logic              en_on,
    input filt_state_t       dly_state,
    input logic [CODE_W-1:0] rise_code
);

    assert_rise_needs_true_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_out) |-> $past(and_res));

    assert_fall_needs_false_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(term_out) |-> !$past(and_res));

    assert_disable_kills_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_on |-> !and_res);

    assert_glitch_aborts_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_state == RISE_WAIT && !and_res) |=> (dly_state == OUT_LOW && !term_out));

    assert_zero_code_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_state == OUT_LOW && and_res && rise_code == '0) |=> term_out);

endmodule

bind pterm_delay pterm_delay_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .term_out  (term_out),
    .and_res   (and_res),
    .en_on     (func_en),
    .dly_state (dly_state),
    .rise_code (rise_code)
);

// File: tb/pterm_delay_test.sv
module pterm_delay_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] blk_in = '0;
    logic [6:0] sfault_in = 7'h7F;
    logic [3:0] gp_in = '0;
    logic [1:0] wdog_in = '0;
    logic       term_out;

    int unsigned cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int unsigned at_q[$];
    bit          val_q[$];
    string       tag_q[$];

    pterm_delay uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_ms   (tick_ms),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .blk_in    (blk_in),
        .sfault_in (sfault_in),
        .gp_in     (gp_in),
        .wdog_in   (wdog_in),
        .term_out  (term_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare queued expectations at their due edge
    always @(negedge clk) begin
        while (at_q.size() > 0 && at_q[0] <= cyc) begin
            checks++;
            if (at_q[0] < cyc || term_out !== val_q[0]) begin
                errors++;
                $display("FAIL %s: term_out=%0b expected %0b at edge %0d (now %0d)",
                         tag_q[0], term_out, val_q[0], at_q[0], cyc);
            end
            void'(at_q.pop_front());
            void'(val_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_out(input int unsigned ofs, input bit v, input string tag);
        at_q.push_back(cyc + ofs);
        val_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        step();
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        step();
        wr_en   = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: all inputs 1, registers clear
        blk_in = 8'hFF; gp_in = 4'hF; wdog_in = 2'b11; sfault_in = 7'h7F;
        expect_out(1, 1'b0, "R1");
        expect_out(6, 1'b0, "R1");
        repeat (7) step();

        // R12 setup: ignore non-supply, invert supplies, rise 200
        wr(4'h1, 8'hFF);
        wr(4'h5, 8'hF0);
        wr(4'h6, 8'h50);
        wr(4'h2, 8'h7F);
        wr(4'h3, 8'h00);
        wr(4'hC, 8'h80);
        wr(4'h7, 8'h02);
        expect_out(2, 1'b0, "R12");
        repeat (3) step();
        step();
        sfault_in = 7'h00;
        expect_out(200, 1'b0, "R12");
        expect_out(201, 1'b1, "R12 with R2 toggles");
        repeat (50) step();
        blk_in = 8'h55; gp_in = 4'h5; wdog_in = 2'b00;
        repeat (155) step();
        blk_in = 8'hAA; gp_in = 4'hA; wdog_in = 2'b11;
        expect_out(3, 1'b1, "R2");
        repeat (4) step();

        // R9: zero codes follow one clock later
        sfault_in = 7'h08;
        expect_out(1, 1'b0, "R9");
        step(); step();
        wr(4'hC, 8'h00);
        sfault_in = 7'h00;
        expect_out(1, 1'b1, "R9");
        repeat (3) step();

        // R7 fall delay 20, R8 glitches (rise 5)
        wr(4'hC, 8'h35);
        step();
        sfault_in = 7'h01;
        expect_out(20, 1'b1, "R7");
        expect_out(21, 1'b0, "R7");
        repeat (25) step();
        step();
        sfault_in = 7'h00;
        repeat (3) step();
        sfault_in = 7'h01;
        step();
        sfault_in = 7'h00;
        expect_out(5, 1'b0, "R8");
        expect_out(6, 1'b1, "R8");
        repeat (8) step();
        sfault_in = 7'h01;
        repeat (10) step();
        sfault_in = 7'h00;
        expect_out(15, 1'b1, "R8");
        repeat (16) step();

        // R5 enable
        wr(4'hC, 8'h00);
        wr(4'h7, 8'h00);
        expect_out(1, 1'b0, "R5");
        wr(4'h7, 8'h01);
        expect_out(2, 1'b0, "R5");
        wr(4'h7, 8'h02);
        expect_out(1, 1'b1, "R5");
        step(); step();

        // R3 invert on block leg 0 (blk_in = AA, bit0 = 0)
        wr(4'h1, 8'hFE);
        expect_out(1, 1'b0, "R3");
        wr(4'h0, 8'h01);
        expect_out(1, 1'b1, "R3");
        step();
        blk_in = 8'hAB;
        expect_out(1, 1'b0, "R3");
        wr(4'h0, 8'h00);
        expect_out(1, 1'b1, "R3");
        wr(4'h1, 8'hFF);
        expect_out(1, 1'b1, "R3");

        // R4 bit positions: supply 6, general 0, watchdogs
        wr(4'h2, 8'h3F);
        expect_out(1, 1'b0, "R4");
        wr(4'h2, 8'h7F);
        expect_out(1, 1'b1, "R4");
        wr(4'h5, 8'hE0);
        expect_out(1, 1'b0, "R4");
        wr(4'h4, 8'h10);
        expect_out(1, 1'b1, "R4");
        wr(4'h4, 8'h00);
        wr(4'h5, 8'hF0);
        expect_out(1, 1'b1, "R4");
        wr(4'h6, 8'h10);
        expect_out(1, 1'b1, "R4");
        step();
        wdog_in = 2'b10;
        expect_out(1, 1'b0, "R4");
        wr(4'h6, 8'h90);
        expect_out(1, 1'b1, "R4");
        wr(4'h6, 8'h60);
        expect_out(1, 1'b0, "R4");
        step();
        wdog_in = 2'b00;
        expect_out(1, 1'b1, "R4");
        wr(4'h6, 8'h50);
        step(); step();

        // R11 tick gating, rise code 2
        sfault_in = 7'h01;
        step();
        wr(4'hC, 8'h20);
        step();
        tick_ms = 1'b0;
        sfault_in = 7'h00;
        expect_out(10, 1'b0, "R11");
        repeat (10) step();
        tick_ms = 1'b1;
        expect_out(1, 1'b0, "R11");
        expect_out(2, 1'b1, "R11");
        repeat (4) step();

        // R10 restart on delay rewrite
        wr(4'hC, 8'h00);
        sfault_in = 7'h01;
        step();
        wr(4'hC, 8'h80);
        step();
        sfault_in = 7'h00;
        repeat (100) step();
        wr(4'hC, 8'h30);
        expect_out(4, 1'b0, "R10");
        expect_out(5, 1'b1, "R10");
        repeat (8) step();

        while (at_q.size() > 0) step();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected under %0d",
                     cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule